// File: doc/BRIEF.md
# Per-Line Outstanding Request Tracker

This block sits between a processor-side request port and the memory system. It admits memory requests, tracks each one against the cache line it touches until that line's completion comes back, and answers every request it takes with one of three verdicts: issued, aliased or buffer-full. A combinational front end turns the access attributes (read, write or flush, plus the linked, locked, fetch and store-check flags) into two type codes. The tracking type is stored with the entry. The downstream type travels with the issued request.

Accepted requests go into one of two small fully associative tables. Write-class requests go into one, read-class requests into the other. A line may hold at most one outstanding request across both tables. A second request to a busy line is refused rather than merged or queued, and the kind of conflict is counted. Completions arrive on separate read and write ports, addressed by line number. A completion frees the matching entry and reports the stored type and request ID. A completion that matches nothing raises a miss flag. Issued requests leave through a one-deep valid/ready stage, and new requests are taken only while that stage can move.

Top module: `line_req_tracker`

## Requirements
- R1: When the outstanding count, after same-cycle completions, has reached MAX_OUT, a taken request is answered buffer-full (status 3). This check comes before any alias check, and no table or counter changes.
- R2: Classification (type codes: load 0, fetch 1, store 2, read-for-modify 3, linked load 4, conditional store 5, locked read 6, locked write 7, flush 8, atomic 9). The op field is read 0, write 1, flush 2. With the linked flag set, the tracking type is 5 for a write and 4 otherwise, and the downstream type is 9. Otherwise, with the locked flag set, the tracking type is 7 for a write and 6 otherwise, and the downstream type is 2. Otherwise a flush is 8/8 and a write is 2/2. A read with the fetch flag is 1/1, a read with the store-check flag is 3/2, and any other read is 0/0.
- R3: Requests with tracking type 0 or 1 are held in the read table and freed only through the read completion port. All other types are held in the write table and freed only through the write completion port.
- R4: A write-class request whose line is held in the read table, or a read-class request whose line is held in the write table, is answered aliased (status 2).
- R5: A request whose line is already held in its own table is answered aliased, and no second entry is created.
- R6: The outstanding count output rises by one per issued request and falls by one per matched completion. It always equals the total number of occupied entries in both tables, and it is 0 after reset.
- R7: Four saturating-free counters record aliased refusals by kind: write blocked by read, write blocked by write, read blocked by write, and read blocked by read.
- R8: A completion that matches an entry frees it. One cycle later it pulses the port's done output, together with the stored tracking type and request ID. A completion that matches no entry pulses the port's miss output instead.
- R9: A completion and a request in the same cycle are handled completion first. The freed line, and the freed count slot, are available to that request.
- R10: An issued request appears on the issue output in the cycle after it is taken, with its full address, downstream type and ID. It is held stable while the issue output is stalled. A request is taken only when the issue stage is empty or draining (req_ready).
- R11: Line identity ignores the low log2(LINE_BYTES) address bits. Every response to a taken request is a one-cycle rsp_valid pulse carrying the request ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request will be taken this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 flush |
| req_linked | input | 1 | Linked load / conditional store access |
| req_locked | input | 1 | Locked read-modify-write access |
| req_fetch | input | 1 | Instruction fetch read |
| req_stchk | input | 1 | Read intended for modify |
| req_addr | input | ADDR_W | Byte address |
| req_id | input | ID_W | Request tag |
| rsp_valid | output | 1 | Verdict for last taken request |
| rsp_status | output | 2 | 1 issued, 2 aliased, 3 buffer-full |
| rsp_id | output | ID_W | Tag of the answered request |
| iss_valid | output | 1 | Downstream request valid |
| iss_ready | input | 1 | Downstream accepts |
| iss_addr | output | ADDR_W | Downstream address |
| iss_type | output | 4 | Downstream type code |
| iss_id | output | ID_W | Downstream tag |
| rcmp_valid | input | 1 | Read completion present |
| rcmp_line | input | ADDR_W-log2(LINE_BYTES) | Read completion line number |
| rcmp_done | output | 1 | Read entry freed |
| rcmp_miss | output | 1 | Read completion matched nothing |
| rcmp_type | output | 4 | Tracking type of freed read entry |
| rcmp_id | output | ID_W | Tag of freed read entry |
| wcmp_valid | input | 1 | Write completion present |
| wcmp_line | input | ADDR_W-log2(LINE_BYTES) | Write completion line number |
| wcmp_done | output | 1 | Write entry freed |
| wcmp_miss | output | 1 | Write completion matched nothing |
| wcmp_type | output | 4 | Tracking type of freed write entry |
| wcmp_id | output | ID_W | Tag of freed write entry |
| out_cnt | output | log2(MAX_OUT+1) | Outstanding request count |
| cnt_wr_on_rd | output | CNT_W | Write refused by read entry |
| cnt_wr_on_wr | output | CNT_W | Write refused by write entry |
| cnt_rd_on_wr | output | CNT_W | Read refused by write entry |
| cnt_rd_on_rd | output | CNT_W | Read refused by read entry |

## Verification
The case that matters is a completion and a new request landing in the same cycle. The ordering decides whether the request sees a full tracker or a busy line. The bench fills the tracker to MAX_OUT and then drives a read completion together with a load to a fresh line. It expects issued rather than buffer-full, and the count to stay at MAX_OUT. It then completes a line and re-requests that same line in one cycle, and expects issued rather than aliased. Both verdicts and the done pulse are sampled one cycle after the shared edge.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

  typedef enum logic [3:0] {
    T_LOAD  = 4'd0,
    T_FETCH = 4'd1,
    T_STORE = 4'd2,
    T_RFM   = 4'd3,
    T_LINK  = 4'd4,
    T_COND  = 4'd5,
    T_LKRD  = 4'd6,
    T_LKWR  = 4'd7,
    T_FLUSH = 4'd8,
    T_ATOM  = 4'd9
  } rtype_e;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_FLUSH = 2'd2;

  localparam logic [1:0] RS_NONE   = 2'd0;
  localparam logic [1:0] RS_ISSUED = 2'd1;
  localparam logic [1:0] RS_ALIAS  = 2'd2;
  localparam logic [1:0] RS_FULL   = 2'd3;

  typedef struct packed {
    rtype_e prim;
    rtype_e sec;
    logic   wr_class;
  } cls_t;

endpackage

// File: rtl/lrt_classify.sv
module lrt_classify
  import lrt_pkg::*;
(
  input  logic [1:0] op,
  input  logic       linked,
  input  logic       locked,
  input  logic       fetch,
  input  logic       stchk,
  output cls_t       cls
);

  always_comb begin
    cls.prim = T_LOAD;
    cls.sec  = T_LOAD;
    if (linked) begin
      if (op == OP_WRITE) cls.prim = T_COND;
      else                cls.prim = T_LINK;
      cls.sec = T_ATOM;
    end else if (locked) begin
      if (op == OP_WRITE) cls.prim = T_LKWR;
      else                cls.prim = T_LKRD;
      cls.sec = T_STORE;
    end else if (op == OP_WRITE) begin
      cls.prim = T_STORE;
      cls.sec  = T_STORE;
    end else if (op == OP_FLUSH) begin
      cls.prim = T_FLUSH;
      cls.sec  = T_FLUSH;
    end else if (fetch) begin
      cls.prim = T_FETCH;
      cls.sec  = T_FETCH;
    end else if (stchk) begin
      cls.prim = T_RFM;
      cls.sec  = T_STORE;
    end
    cls.wr_class = !((cls.prim == T_LOAD) || (cls.prim == T_FETCH));
  end

endmodule

// File: rtl/lrt_cam.sv
module lrt_cam
  import lrt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 26,
  parameter int ID_W  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  rtype_e           ins_type,
  input  logic [ID_W-1:0]  ins_id,
  output logic             clr_hit,
  output rtype_e           clr_type,
  output logic [ID_W-1:0]  clr_id,
  output logic             look_hit,
  output logic             has_free,
  output logic [OCC_W-1:0] occ
);

  logic [DEPTH-1:0] vld, clr_m, look_m, clr_sel, vld_kept;
  logic [TAG_W-1:0] tag_q [DEPTH];
  rtype_e           typ_q [DEPTH];
  logic [ID_W-1:0]  id_q  [DEPTH];
  logic [IDX_W-1:0] free_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign clr_m[g]  = vld[g] && (tag_q[g] == clr_tag);
    assign look_m[g] = vld[g] && (tag_q[g] == look_tag);
  end

  always_comb begin
    clr_hit  = 1'b0;
    clr_type = T_LOAD;
    clr_id   = '0;
    clr_sel  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (clr_m[i] && !clr_hit) begin
        clr_hit    = 1'b1;
        clr_sel[i] = 1'b1;
        clr_type   = typ_q[i];
        clr_id     = id_q[i];
      end
    end
  end

  assign vld_kept = clr_en ? (vld & ~clr_sel) : vld;
  assign look_hit = |(look_m & vld_kept);

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_kept[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) occ = occ + OCC_W'(vld[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      vld <= vld_kept;
      if (ins_en) vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_q[free_idx] <= ins_tag;
      typ_q[free_idx] <= ins_type;
      id_q[free_idx]  <= ins_id;
    end
  end

  // R5: a line never occupies two entries of one table
  p_no_dup_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(look_m));

  // R1: an insert is only requested when a slot is free
  p_ins_room_r1: assert property (@(posedge clk) disable iff (rst)
    ins_en |-> has_free);

endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
  import lrt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ID_W       = 4,
  parameter int DEPTH      = 8,
  parameter int MAX_OUT    = 8,
  parameter int CNT_W      = 16,
  localparam int OFS_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - OFS_W,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int OUT_W = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_linked,
  input  logic              req_locked,
  input  logic              req_fetch,
  input  logic              req_stchk,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [ID_W-1:0]   rsp_id,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [3:0]        iss_type,
  output logic [ID_W-1:0]   iss_id,
  input  logic              rcmp_valid,
  input  logic [TAG_W-1:0]  rcmp_line,
  output logic              rcmp_done,
  output logic              rcmp_miss,
  output logic [3:0]        rcmp_type,
  output logic [ID_W-1:0]   rcmp_id,
  input  logic              wcmp_valid,
  input  logic [TAG_W-1:0]  wcmp_line,
  output logic              wcmp_done,
  output logic              wcmp_miss,
  output logic [3:0]        wcmp_type,
  output logic [ID_W-1:0]   wcmp_id,
  output logic [OUT_W-1:0]  out_cnt,
  output logic [CNT_W-1:0]  cnt_wr_on_rd,
  output logic [CNT_W-1:0]  cnt_wr_on_wr,
  output logic [CNT_W-1:0]  cnt_rd_on_wr,
  output logic [CNT_W-1:0]  cnt_rd_on_rd
);

  cls_t             cls;
  logic [TAG_W-1:0] req_tag;
  logic             take, full, hit_other, hit_own, accept;
  logic             rd_ins, wr_ins, rd_free_now, wr_free_now;
  logic [OUT_W:0]   cnt_after, cnt_next;

  logic             rd_clr_hit, rd_look_hit, rd_has_free;
  logic             wr_clr_hit, wr_look_hit, wr_has_free;
  rtype_e           rd_clr_type, wr_clr_type;
  logic [ID_W-1:0]  rd_clr_id, wr_clr_id;
  logic [OCC_W-1:0] rd_occ, wr_occ;

  lrt_classify u_cls (
    .op(req_op), .linked(req_linked), .locked(req_locked),
    .fetch(req_fetch), .stchk(req_stchk), .cls(cls)
  );

  assign req_tag = req_addr[ADDR_W-1:OFS_W];

  lrt_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ID_W(ID_W)) u_rd_tab (
    .clk(clk), .rst(rst),
    .clr_en(rcmp_valid), .clr_tag(rcmp_line), .look_tag(req_tag),
    .ins_en(rd_ins), .ins_tag(req_tag), .ins_type(cls.prim), .ins_id(req_id),
    .clr_hit(rd_clr_hit), .clr_type(rd_clr_type), .clr_id(rd_clr_id),
    .look_hit(rd_look_hit), .has_free(rd_has_free), .occ(rd_occ)
  );

  lrt_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ID_W(ID_W)) u_wr_tab (
    .clk(clk), .rst(rst),
    .clr_en(wcmp_valid), .clr_tag(wcmp_line), .look_tag(req_tag),
    .ins_en(wr_ins), .ins_tag(req_tag), .ins_type(cls.prim), .ins_id(req_id),
    .clr_hit(wr_clr_hit), .clr_type(wr_clr_type), .clr_id(wr_clr_id),
    .look_hit(wr_look_hit), .has_free(wr_has_free), .occ(wr_occ)
  );

  assign req_ready   = !iss_valid || iss_ready;
  assign take        = req_valid && req_ready;
  assign rd_free_now = rcmp_valid && rd_clr_hit;
  assign wr_free_now = wcmp_valid && wr_clr_hit;

  // completions retire first, so the request sees the reduced count
  assign cnt_after = {1'b0, out_cnt} - (OUT_W+1)'(rd_free_now)
                                     - (OUT_W+1)'(wr_free_now);
  assign full      = (cnt_after >= (OUT_W+1)'(MAX_OUT)) ||
                     (cls.wr_class ? !wr_has_free : !rd_has_free);
  assign hit_other = cls.wr_class ? rd_look_hit : wr_look_hit;
  assign hit_own   = cls.wr_class ? wr_look_hit : rd_look_hit;
  assign accept    = take && !full && !hit_other && !hit_own;
  assign rd_ins    = accept && !cls.wr_class;
  assign wr_ins    = accept && cls.wr_class;
  assign cnt_next  = cnt_after + (OUT_W+1)'(accept);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_cnt      <= '0;
      rsp_valid    <= 1'b0;
      rsp_status   <= RS_NONE;
      rsp_id       <= '0;
      iss_valid    <= 1'b0;
      iss_addr     <= '0;
      iss_type     <= '0;
      iss_id       <= '0;
      rcmp_done    <= 1'b0;
      rcmp_miss    <= 1'b0;
      rcmp_type    <= '0;
      rcmp_id      <= '0;
      wcmp_done    <= 1'b0;
      wcmp_miss    <= 1'b0;
      wcmp_type    <= '0;
      wcmp_id      <= '0;
      cnt_wr_on_rd <= '0;
      cnt_wr_on_wr <= '0;
      cnt_rd_on_wr <= '0;
      cnt_rd_on_rd <= '0;
    end else begin
      out_cnt   <= OUT_W'(cnt_next);
      rsp_valid <= take;
      rsp_id    <= req_id;
      if (full)                       rsp_status <= RS_FULL;
      else if (hit_other || hit_own)  rsp_status <= RS_ALIAS;
      else                            rsp_status <= RS_ISSUED;

      if (accept) begin
        iss_valid <= 1'b1;
        iss_addr  <= req_addr;
        iss_type  <= cls.sec;
        iss_id    <= req_id;
      end else if (iss_ready) begin
        iss_valid <= 1'b0;
      end

      if (take && !full) begin
        if (cls.wr_class && hit_other)       cnt_wr_on_rd <= cnt_wr_on_rd + 1'b1;
        else if (cls.wr_class && hit_own)    cnt_wr_on_wr <= cnt_wr_on_wr + 1'b1;
        else if (!cls.wr_class && hit_other) cnt_rd_on_wr <= cnt_rd_on_wr + 1'b1;
        else if (!cls.wr_class && hit_own)   cnt_rd_on_rd <= cnt_rd_on_rd + 1'b1;
      end

      rcmp_done <= rd_free_now;
      rcmp_miss <= rcmp_valid && !rd_clr_hit;
      rcmp_type <= rd_clr_type;
      rcmp_id   <= rd_clr_id;
      wcmp_done <= wr_free_now;
      wcmp_miss <= wcmp_valid && !wr_clr_hit;
      wcmp_type <= wr_clr_type;
      wcmp_id   <= wr_clr_id;
    end
  end

  // R6: count tracks the occupied entries of both tables
  p_count_sum_r6: assert property (@(posedge clk) disable iff (rst)
    (OCC_W+1)'(out_cnt) == (OCC_W+1)'(rd_occ) + (OCC_W+1)'(wr_occ));

  // R1: never more outstanding than the configured maximum
  p_cap_r1: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= OUT_W'(MAX_OUT));

  // R10: an issued verdict comes with a live issue output
  p_issue_seen_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == RS_ISSUED) |-> iss_valid);

  // R10: a stalled issue output holds its payload
  p_issue_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_addr) && $stable(iss_type)));

  // R8: a completion is either matched or missed, never both
  p_rd_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(rcmp_done && rcmp_miss));
  p_wr_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(wcmp_done && wcmp_miss));

endmodule

// File: tb/line_req_tracker_tb.sv
`timescale 1ns/1ps
module line_req_tracker_tb_top;

  localparam int AW = 32;
  localparam int TW = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_linked = 0, req_locked = 0, req_fetch = 0, req_stchk = 0;
  logic [1:0]    req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [3:0]    req_id = 0;
  logic          iss_ready = 1;
  logic          rcmp_valid = 0, wcmp_valid = 0;
  logic [TW-1:0] rcmp_line = 0, wcmp_line = 0;

  logic          req_ready, rsp_valid, iss_valid;
  logic [1:0]    rsp_status;
  logic [3:0]    rsp_id, iss_type, iss_id, rcmp_type, rcmp_id, wcmp_type, wcmp_id;
  logic [AW-1:0] iss_addr;
  logic          rcmp_done, rcmp_miss, wcmp_done, wcmp_miss;
  logic [3:0]    out_cnt;
  logic [15:0]   cnt_wr_on_rd, cnt_wr_on_wr, cnt_rd_on_wr, cnt_rd_on_rd;

  line_req_tracker dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_linked(req_linked), .req_locked(req_locked), .req_fetch(req_fetch),
    .req_stchk(req_stchk), .req_addr(req_addr), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_id(rsp_id),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr),
    .iss_type(iss_type), .iss_id(iss_id),
    .rcmp_valid(rcmp_valid), .rcmp_line(rcmp_line), .rcmp_done(rcmp_done),
    .rcmp_miss(rcmp_miss), .rcmp_type(rcmp_type), .rcmp_id(rcmp_id),
    .wcmp_valid(wcmp_valid), .wcmp_line(wcmp_line), .wcmp_done(wcmp_done),
    .wcmp_miss(wcmp_miss), .wcmp_type(wcmp_type), .wcmp_id(wcmp_id),
    .out_cnt(out_cnt),
    .cnt_wr_on_rd(cnt_wr_on_rd), .cnt_wr_on_wr(cnt_wr_on_wr),
    .cnt_rd_on_wr(cnt_rd_on_wr), .cnt_rd_on_rd(cnt_rd_on_rd)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic drive_req(input logic [1:0] op, input logic lnk, input logic lk,
                           input logic fe, input logic sc, input logic [31:0] addr,
                           input logic [3:0] id);
    req_valid = 1; req_op = op; req_linked = lnk; req_locked = lk;
    req_fetch = fe; req_stchk = sc; req_addr = addr; req_id = id;
  endtask

  task automatic idle_req();
    req_valid = 0; req_linked = 0; req_locked = 0; req_fetch = 0; req_stchk = 0;
  endtask

  task automatic do_req(input logic [1:0] op, input logic lnk, input logic lk,
                        input logic fe, input logic sc, input logic [31:0] addr,
                        input logic [3:0] id);
    drive_req(op, lnk, lk, fe, sc, addr, id);
    @(negedge clk);
    idle_req();
  endtask

  task automatic do_cmp(input logic wr, input logic [31:0] addr);
    if (wr) begin wcmp_valid = 1; wcmp_line = addr[31:6]; end
    else    begin rcmp_valid = 1; rcmp_line = addr[31:6]; end
    @(negedge clk);
    rcmp_valid = 0; wcmp_valid = 0;
  endtask

  task automatic t_reset();
    chk("R6", "out_cnt after reset", out_cnt, 0);
    chk("R11", "rsp_valid after reset", rsp_valid, 0);
    chk("R10", "iss_valid after reset", iss_valid, 0);
    chk("R10", "req_ready after reset", req_ready, 1);
    chk("R7", "counters after reset",
        cnt_wr_on_rd | cnt_wr_on_wr | cnt_rd_on_wr | cnt_rd_on_rd, 0);
  endtask

  task automatic t_classify();
    for (int k = 0; k < 10; k++) begin
      logic [1:0] op; logic lnk, lk, fe, sc, wr; logic [3:0] pr, se;
      logic [31:0] a;
      lnk = 0; lk = 0; fe = 0; sc = 0;
      case (k)
        0: begin op = 0;                 pr = 0; se = 0; wr = 0; end
        1: begin op = 0; fe = 1;         pr = 1; se = 1; wr = 0; end
        2: begin op = 0; sc = 1;         pr = 3; se = 2; wr = 1; end
        3: begin op = 1;                 pr = 2; se = 2; wr = 1; end
        4: begin op = 2;                 pr = 8; se = 8; wr = 1; end
        5: begin op = 0; lnk = 1;        pr = 4; se = 9; wr = 1; end
        6: begin op = 1; lnk = 1;        pr = 5; se = 9; wr = 1; end
        7: begin op = 0; lk = 1;         pr = 6; se = 2; wr = 1; end
        8: begin op = 1; lk = 1;         pr = 7; se = 2; wr = 1; end
        default: begin op = 0; lnk = 1; lk = 1; pr = 4; se = 9; wr = 1; end
      endcase
      a = 32'h1000 + k * 64 + 5;
      do_req(op, lnk, lk, fe, sc, a, 4'(k));
      chk("R2", "status", rsp_status, 1);
      chk("R2", "downstream type", iss_type, se);
      chk("R10", "issue addr", iss_addr, a);
      chk("R11", "rsp id", rsp_id, k);
      chk("R6", "count after issue", out_cnt, 1);
      do_cmp(!wr, a);
      chk("R3", "wrong-port miss", wr ? rcmp_miss : wcmp_miss, 1);
      chk("R3", "wrong-port done", wr ? rcmp_done : wcmp_done, 0);
      do_cmp(wr, a);
      chk("R8", "done", wr ? wcmp_done : rcmp_done, 1);
      chk("R2", "tracking type", wr ? wcmp_type : rcmp_type, pr);
      chk("R8", "stored id", wr ? wcmp_id : rcmp_id, k);
      chk("R6", "count after completion", out_cnt, 0);
    end
  endtask

  task automatic t_alias();
    do_req(0, 0, 0, 0, 0, 32'h2000, 4'd1);
    chk("R4", "load A issued", rsp_status, 1);
    do_req(1, 0, 0, 0, 0, 32'h2008, 4'd2);
    chk("R4", "store on loaded line", rsp_status, 2);
    chk("R7", "wr_on_rd", cnt_wr_on_rd, 1);
    do_req(0, 0, 0, 0, 0, 32'h2004, 4'd3);
    chk("R5", "load on loaded line", rsp_status, 2);
    chk("R7", "rd_on_rd", cnt_rd_on_rd, 1);
    chk("R5", "no second entry", out_cnt, 1);
    do_cmp(0, 32'h2030);
    chk("R11", "completion ignores offset", rcmp_done, 1);
    chk("R8", "id of A", rcmp_id, 1);
    do_req(1, 0, 0, 0, 0, 32'h3000, 4'd4);
    chk("R4", "store B issued", rsp_status, 1);
    do_req(0, 0, 0, 0, 0, 32'h3001, 4'd5);
    chk("R4", "load on stored line", rsp_status, 2);
    chk("R7", "rd_on_wr", cnt_rd_on_wr, 1);
    do_req(2, 0, 0, 0, 0, 32'h303F, 4'd6);
    chk("R5", "flush on stored line", rsp_status, 2);
    chk("R7", "wr_on_wr", cnt_wr_on_wr, 1);
    chk("R7", "rd_on_rd unchanged", cnt_rd_on_rd, 1);
    do_cmp(1, 32'h3000);
    chk("R8", "store done type", wcmp_type, 2);
    chk("R6", "drained", out_cnt, 0);
  endtask

  task automatic t_full_and_same_cycle();
    for (int i = 0; i < 8; i++) begin
      do_req(0, 0, 0, 0, 0, 32'h8000 + i * 64, 4'(i));
      chk("R1", "fill issued", rsp_status, 1);
    end
    chk("R6", "count full", out_cnt, 8);
    do_req(0, 0, 0, 0, 0, 32'h8000, 4'd9);
    chk("R1", "full beats alias", rsp_status, 3);
    chk("R1", "no alias counted", cnt_rd_on_rd, 1);
    do_req(1, 0, 0, 0, 0, 32'h9000, 4'd10);
    chk("R1", "store when full", rsp_status, 3);
    chk("R1", "count unchanged", out_cnt, 8);
    // R9: completion frees the slot for the request in the same cycle
    drive_req(0, 0, 0, 0, 0, 32'h9000, 4'd8);
    rcmp_valid = 1; rcmp_line = 26'h200;
    @(negedge clk);
    idle_req(); rcmp_valid = 0;
    chk("R9", "slot reuse status", rsp_status, 1);
    chk("R9", "slot reuse done", rcmp_done, 1);
    chk("R9", "count stays", out_cnt, 8);
    // R9: freed line readmitted at once
    drive_req(0, 0, 0, 0, 0, 32'h8040, 4'd11);
    rcmp_valid = 1; rcmp_line = 26'h201;
    @(negedge clk);
    idle_req(); rcmp_valid = 0;
    chk("R9", "line reuse status", rsp_status, 1);
    chk("R9", "line reuse old id", rcmp_id, 1);
    for (int i = 2; i < 8; i++) do_cmp(0, 32'h8000 + i * 64);
    do_cmp(0, 32'h9000);
    chk("R8", "id of late load", rcmp_id, 8);
    do_cmp(0, 32'h8040);
    chk("R8", "id of readmitted", rcmp_id, 11);
    chk("R6", "empty again", out_cnt, 0);
  endtask

  task automatic t_backpressure();
    iss_ready = 0;
    do_req(0, 0, 0, 0, 0, 32'hA000, 4'd3);
    chk("R10", "stalled issue valid", iss_valid, 1);
    chk("R10", "not ready", req_ready, 0);
    drive_req(0, 0, 0, 0, 0, 32'hB000, 4'd7);
    @(negedge clk);
    idle_req();
    chk("R10", "request not taken", rsp_valid, 0);
    chk("R10", "held addr", iss_addr, 32'hA000);
    chk("R6", "count one", out_cnt, 1);
    iss_ready = 1;
    @(negedge clk);
    chk("R10", "issue drained", iss_valid, 0);
    chk("R10", "ready again", req_ready, 1);
    do_cmp(0, 32'hA000);
    chk("R8", "bp done", rcmp_done, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_classify();
    t_alias();
    t_full_and_same_cycle();
    t_backpressure();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule